// File: doc/BRIEF.md
# DMA Mode, Status and Autoload Controller

This block holds the control state of a four-channel DMA engine: an 8-bit mode register written by the CPU and an 8-bit status register the CPU reads. The mode register turns each channel on or off, selects rotating or fixed arbitration order (passed on to the arbiter), lengthens the active-low write strobes, arms stop-on-terminal-count, and arms autoload. The status register latches a terminal-count flag per channel and an update flag that marks a reload of channel 2.

Terminal-count pulses come in from the channel counters. With stop-on-terminal-count armed, a channel that finishes has its enable bit dropped. With autoload armed, channel 3 is withheld from service as a spare parameter store. When channel 2 finishes, the block pulses a reload strobe so the channel datapath copies the channel-3 address and count into channel 2, and it raises the update flag. Channel 2 stays enabled. Reading the status register clears the latched flags. An event that lands in the same cycle as the read is kept for the next read.

Top module: `dmams_top`

## Requirements
- R1: After a synchronous reset, the mode register is 0x00 and the status register reads 0x00. All enables, `prio_rotate`, `ext_write`, `autoload_on` and `reload_stb` are 0.
- R2: When `mode_wr` is 1, the next cycle holds `mode_wdata` in the mode register. Bits 3:0 drive `ch_en[3:0]`, bit 4 drives `prio_rotate`, bit 5 drives `ext_write` and bit 7 drives `autoload_on`.
- R3: A 1 on `tc_in[i]` sets status bit i from the next cycle on. `status_rdata` is {3'b000, update flag, tc flags[3:0]}, so bits 7:5 always read 0.
- R4: A cycle with `stat_rd` high clears every terminal-count flag and the update flag at the clock edge. A `tc_in` bit asserted in that same cycle is still set afterwards.
- R5: With mode bit 6 set, `tc_in[i]` clears mode enable bit i in the next cycle. With bit 6 clear, the enables are unchanged.
- R6: While mode bit 7 (autoload) is set, `ch_en[3]` is 0 whatever mode bit 3 holds.
- R7: With autoload set, `tc_in[2]` gives a one-cycle `reload_stb` pulse and sets the update flag (status bit 4) in the next cycle. Channel 2 keeps its enable even when stop-on-terminal-count is set.
- R8: The update flag clears after a cycle with `ch2_xfer_start` high. If a new reload is triggered in that same cycle, the flag stays set.
- R9: A mode write in the same cycle as a stop-on-terminal-count event takes precedence; the written value is loaded unchanged.
- R10: With autoload clear, `tc_in[2]` produces no `reload_stb` and does not set the update flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wr | input | 1 | CPU write strobe for the mode register |
| mode_wdata | input | 8 | Data written into the mode register |
| stat_rd | input | 1 | CPU read strobe for the status register; clears flags at the edge |
| tc_in | input | 4 | Per-channel terminal-count pulse |
| ch2_xfer_start | input | 1 | Channel 2 begins a transfer |
| status_rdata | output | 8 | Current status register contents |
| ch_en | output | 4 | Per-channel service enable |
| prio_rotate | output | 1 | Rotating arbitration order selected |
| ext_write | output | 1 | Lengthen the write strobes |
| autoload_on | output | 1 | Autoload mode armed |
| reload_stb | output | 1 | Copy channel-3 parameters into channel 2 |

## Verification
On every cycle, the embedded assertions check the following: a mode write is loaded as written, a terminal-count pulse is captured, a status read clears each flag unless a new event comes in, an armed stop drops the matching enable, a reload strobe is only produced under autoload and always comes with the update flag, and the flag clears on a read or a channel-2 start. Several behaviours need the bench's scenarios. These are the masking of channel 3 under autoload, the survival of channel 2's enable at its terminal count, the write-over-stop precedence, a same-cycle event and read, and a reload that coincides with a flag clear. The bench checks them with directed sequences against a cycle model.

// File: rtl/dmams_pkg.sv
package dmams_pkg;

    localparam int NUM_CH     = 4;
    localparam int RELOAD_CH  = 2;
    localparam int SPARE_CH   = 3;
    localparam int REG_W      = 8;
    localparam int STAT_RSV_W = REG_W - NUM_CH - 1;

    // Field order follows the register bit layout, most significant first.
    typedef struct packed {
        logic              autoload;
        logic              stop_tc;
        logic              ext_wr;
        logic              rotate;
        logic [NUM_CH-1:0] ch_on;
    } mode_t;

    typedef struct packed {
        logic [STAT_RSV_W-1:0] rsv;
        logic                  update;
        logic [NUM_CH-1:0]     tc_seen;
    } status_t;

    // Channels that may be served: the spare is withheld under autoload.
    function automatic logic [NUM_CH-1:0] serve_mask(input logic autoload);
        logic [NUM_CH-1:0] m;
        m = '1;
        if (autoload) m[SPARE_CH] = 1'b0;
        return m;
    endfunction

    function automatic status_t pack_status(input logic upd,
                                            input logic [NUM_CH-1:0] tc);
        status_t s;
        s.rsv     = '0;
        s.update  = upd;
        s.tc_seen = tc;
        return s;
    endfunction

endpackage

// File: rtl/dmams_mode_reg.sv
module dmams_mode_reg
    import dmams_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  mode_t             wdata,
    input  logic [NUM_CH-1:0] tc_in,
    output mode_t             mode_q
);

    logic [NUM_CH-1:0] kill;
    mode_t             mode_d;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_kill
        localparam bit IS_RELOAD = (i == RELOAD_CH);
        // The reload channel survives its terminal count under autoload.
        assign kill[i] = mode_q.stop_tc && tc_in[i]
                         && !(IS_RELOAD && mode_q.autoload);

        AST_STOP_DROPS_EN: assert property (@(posedge clk) disable iff (rst)
            (!wr_en && kill[i]) |=> !mode_q.ch_on[i]); // R5
    end

    always_comb begin
        mode_d = mode_q;
        if (wr_en) begin
            mode_d = wdata;
        end else begin
            mode_d.ch_on = mode_q.ch_on & ~kill;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) mode_q <= '0;
        else     mode_q <= mode_d;
    end

    AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (mode_q == $past(wdata))); // R9

endmodule

// File: rtl/dmams_tc_status.sv
module dmams_tc_status
    import dmams_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_clr,
    input  logic [NUM_CH-1:0] tc_in,
    output logic [NUM_CH-1:0] tc_q
);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)         tc_q[i] <= 1'b0;
            else if (tc_in[i]) tc_q[i] <= 1'b1;
            else if (rd_clr) tc_q[i] <= 1'b0;
        end

        AST_TC_CAPTURE: assert property (@(posedge clk) disable iff (rst)
            tc_in[i] |=> tc_q[i]); // R3
        AST_RD_CLEARS: assert property (@(posedge clk) disable iff (rst)
            (rd_clr && !tc_in[i]) |=> !tc_q[i]); // R4
    end

endmodule

// File: rtl/dmams_autoload.sv
module dmams_autoload (
    input  logic clk,
    input  logic rst,
    input  logic autoload,
    input  logic reload_tc,
    input  logic rd_clr,
    input  logic xfer_start,
    output logic reload_stb,
    output logic update_q
);

    logic fire;
    assign fire = autoload && reload_tc;

    always_ff @(posedge clk) begin
        if (rst) begin
            reload_stb <= 1'b0;
            update_q   <= 1'b0;
        end else begin
            reload_stb <= fire;
            if (fire)                      update_q <= 1'b1;
            else if (rd_clr || xfer_start) update_q <= 1'b0;
        end
    end

    AST_NO_RELOAD_OFF: assert property (@(posedge clk) disable iff (rst)
        (!autoload && reload_tc) |=> !reload_stb); // R10
    AST_RELOAD_FLAGS: assert property (@(posedge clk) disable iff (rst)
        reload_stb |-> update_q); // R7
    AST_UPD_CLEAR: assert property (@(posedge clk) disable iff (rst)
        ((rd_clr || xfer_start) && !fire) |=> !update_q); // R8

endmodule

// File: rtl/dmams_top.sv
module dmams_top
    import dmams_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       mode_wr,
    input  logic [7:0] mode_wdata,
    input  logic       stat_rd,
    input  logic [3:0] tc_in,
    input  logic       ch2_xfer_start,
    output logic [7:0] status_rdata,
    output logic [3:0] ch_en,
    output logic       prio_rotate,
    output logic       ext_write,
    output logic       autoload_on,
    output logic       reload_stb
);

    mode_t             mode_q;
    logic [NUM_CH-1:0] tc_q;
    logic              update_q;

    dmams_mode_reg u_mode (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (mode_wr),
        .wdata  (mode_t'(mode_wdata)),
        .tc_in  (tc_in),
        .mode_q (mode_q)
    );

    dmams_tc_status u_stat (
        .clk    (clk),
        .rst    (rst),
        .rd_clr (stat_rd),
        .tc_in  (tc_in),
        .tc_q   (tc_q)
    );

    dmams_autoload u_auto (
        .clk        (clk),
        .rst        (rst),
        .autoload   (mode_q.autoload),
        .reload_tc  (tc_in[RELOAD_CH]),
        .rd_clr     (stat_rd),
        .xfer_start (ch2_xfer_start),
        .reload_stb (reload_stb),
        .update_q   (update_q)
    );

    assign status_rdata = pack_status(update_q, tc_q);
    assign ch_en        = mode_q.ch_on & serve_mask(mode_q.autoload);
    assign prio_rotate  = mode_q.rotate;
    assign ext_write    = mode_q.ext_wr;
    assign autoload_on  = mode_q.autoload;

endmodule

// File: tb/dmams_top_bench.sv
module dmams_top_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic       mode_wr;
    logic [7:0] mode_wdata;
    logic       stat_rd;
    logic [3:0] tc_in;
    logic       ch2_xfer_start;
    logic [7:0] status_rdata;
    logic [3:0] ch_en;
    logic       prio_rotate, ext_write, autoload_on, reload_stb;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #10 clk = ~clk;  // 50 MHz

    dmams_top u_dmams_top (
        .clk(clk), .rst(rst), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
        .stat_rd(stat_rd), .tc_in(tc_in), .ch2_xfer_start(ch2_xfer_start),
        .status_rdata(status_rdata), .ch_en(ch_en), .prio_rotate(prio_rotate),
        .ext_write(ext_write), .autoload_on(autoload_on), .reload_stb(reload_stb)
    );

    // Behavioural reference model, updated on each rising edge.
    logic [7:0] m_mode;
    logic [3:0] m_tc;
    logic       m_upd, m_rel;

    always @(posedge clk) begin
        logic fire;
        logic [7:0] nm;
        if (rst) begin
            m_mode = 8'h00; m_tc = 4'h0; m_upd = 1'b0; m_rel = 1'b0;
        end else begin
            fire = m_mode[7] && tc_in[2];
            nm = m_mode;
            if (mode_wr) nm = mode_wdata;
            else if (m_mode[6]) begin
                for (int i = 0; i < 4; i++)
                    if (tc_in[i] && !(i == 2 && m_mode[7])) nm[i] = 1'b0;
            end
            m_mode = nm;
            m_tc   = (stat_rd ? 4'h0 : m_tc) | tc_in;
            if (fire) m_upd = 1'b1;
            else if (stat_rd || ch2_xfer_start) m_upd = 1'b0;
            m_rel = fire;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic compare_model();
        logic [3:0] exp_en;
        exp_en = m_mode[3:0];
        if (m_mode[7]) exp_en[3] = 1'b0;
        chk("R6 model ch_en", {28'd0, ch_en}, {28'd0, exp_en});
        chk("R3 model status", {24'd0, status_rdata}, {24'd0, 3'b000, m_upd, m_tc});
        chk("R7 model reload", {31'd0, reload_stb}, {31'd0, m_rel});
        chk("R2 model mode outs", {29'd0, prio_rotate, ext_write, autoload_on},
            {29'd0, m_mode[4], m_mode[5], m_mode[7]});
    endtask

    // Apply inputs for one cycle, then sample at the falling edge.
    task automatic cyc(input logic wr, input logic [7:0] wd, input logic rd,
                       input logic [3:0] tc, input logic xs);
        mode_wr = wr; mode_wdata = wd; stat_rd = rd; tc_in = tc; ch2_xfer_start = xs;
        @(posedge clk);
        @(negedge clk);
        mode_wr = 1'b0; stat_rd = 1'b0; tc_in = 4'h0; ch2_xfer_start = 1'b0;
        compare_model();
    endtask

    task automatic idle();
        cyc(1'b0, 8'h00, 1'b0, 4'h0, 1'b0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        rst = 1'b1; mode_wr = 0; mode_wdata = 0; stat_rd = 0; tc_in = 0; ch2_xfer_start = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 status", {24'd0, status_rdata}, 32'h00);
        chk("R1 ch_en", {28'd0, ch_en}, 32'h0);
        chk("R1 flags", {28'd0, prio_rotate, ext_write, autoload_on, reload_stb}, 32'h0);

        // R2 mode fields
        cyc(1'b1, 8'h2F, 1'b0, 4'h0, 1'b0);
        chk("R2 ch_en", {28'd0, ch_en}, 32'hF);
        chk("R2 ext_write", {31'd0, ext_write}, 32'h1);
        chk("R2 prio", {31'd0, prio_rotate}, 32'h0);
        cyc(1'b1, 8'h15, 1'b0, 4'h0, 1'b0);
        chk("R2 prio set", {31'd0, prio_rotate}, 32'h1);
        chk("R2 ch_en 5", {28'd0, ch_en}, 32'h5);

        // R3 capture, R4 read clear
        cyc(1'b0, 8'h00, 1'b0, 4'h5, 1'b0);
        chk("R3 tc capture", {24'd0, status_rdata}, 32'h05);
        cyc(1'b0, 8'h00, 1'b0, 4'h8, 1'b0);
        chk("R3 tc accumulate", {24'd0, status_rdata}, 32'h0D);
        cyc(1'b0, 8'h00, 1'b1, 4'h0, 1'b0);
        chk("R4 read clears", {24'd0, status_rdata}, 32'h00);
        cyc(1'b0, 8'h00, 1'b1, 4'h2, 1'b0);
        chk("R4 same-cycle event kept", {24'd0, status_rdata}, 32'h02);
        cyc(1'b0, 8'h00, 1'b1, 4'h0, 1'b0);

        // R5 stop on terminal count
        cyc(1'b1, 8'h4F, 1'b0, 4'h0, 1'b0);
        cyc(1'b0, 8'h00, 1'b0, 4'h1, 1'b0);
        chk("R5 stop drops ch0", {28'd0, ch_en}, 32'hE);
        cyc(1'b1, 8'h0F, 1'b0, 4'h0, 1'b0);
        cyc(1'b0, 8'h00, 1'b0, 4'h1, 1'b0);
        chk("R5 no stop keeps ch0", {28'd0, ch_en}, 32'hF);

        // R9 write beats stop
        cyc(1'b1, 8'h4F, 1'b1, 4'h0, 1'b0);
        cyc(1'b1, 8'h4F, 1'b0, 4'h1, 1'b0);
        chk("R9 write wins", {28'd0, ch_en}, 32'hF);

        // R10 no reload without autoload
        cyc(1'b0, 8'h00, 1'b1, 4'h0, 1'b0);
        cyc(1'b1, 8'h0F, 1'b0, 4'h0, 1'b0);
        cyc(1'b0, 8'h00, 1'b0, 4'h4, 1'b0);
        chk("R10 no strobe", {31'd0, reload_stb}, 32'h0);
        chk("R10 no update", {24'd0, status_rdata}, 32'h04);

        // R6 spare withheld, R7 reload
        cyc(1'b1, 8'hCF, 1'b1, 4'h0, 1'b0);
        chk("R6 ch3 masked", {28'd0, ch_en}, 32'h7);
        chk("R6 autoload out", {31'd0, autoload_on}, 32'h1);
        cyc(1'b0, 8'h00, 1'b0, 4'h4, 1'b0);
        chk("R7 strobe", {31'd0, reload_stb}, 32'h1);
        chk("R7 update flag", {24'd0, status_rdata}, 32'h14);
        chk("R7 ch2 kept", {28'd0, ch_en}, 32'h7);
        idle();
        chk("R7 strobe one cycle", {31'd0, reload_stb}, 32'h0);

        // R8 clear on start, reload wins over clear
        cyc(1'b0, 8'h00, 1'b0, 4'h0, 1'b1);
        chk("R8 start clears update", {24'd0, status_rdata}, 32'h04);
        cyc(1'b0, 8'h00, 1'b0, 4'h4, 1'b1);
        chk("R8 reload beats clear", {24'd0, status_rdata}, 32'h14);
        cyc(1'b0, 8'h00, 1'b1, 4'h0, 1'b0);
        chk("R4 read clears update", {24'd0, status_rdata}, 32'h00);

        // Mixed traffic against the model
        for (int k = 0; k < 40; k++) begin
            cyc((k % 7) == 0, 8'(k * 37), (k % 5) == 0, 4'(k * 3), (k % 4) == 1);
        end

        // R1 reset again mid-run
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        rst = 1'b0;
        chk("R1 re-reset", {20'd0, status_rdata, ch_en}, 32'h0);
        finish_run();
    end

endmodule